// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is the serial front end of a small register file. It watches the clock and data lines of a two-wire, I2C-compatible bus, samples them with a fast system clock, and turns bus transfers into single-cycle read and write strobes on a plain byte-wide register port. The data line is open-drain. The block only ever pulls it low, through `sda_oe`. A bus master first writes a pointer byte and then streams data bytes. It can also issue a repeated start and stream bytes back. The pointer advances by one after each byte.

The register file behind the port has 19 byte locations, 0x00 to 0x12. Locations 0x07 to 0x12 are writable. All 19 can be read. A stop condition always sends the pointer back to 0x00, so a master can poll location 0x00 with bare read transfers. While a read transfer is in progress, `read_active` is held high so that data registers can hold off updates. A general-call command clears the whole register file back to its defaults through `gc_reset`.

Top module: `i2c_regport`

## Requirements
- R1: The slave responds only to address byte 0x90 (write) or 0x91 (read), taken MSB first, and pulls the data line low during the ninth clock. Any other non-zero address byte gets no acknowledge, and the slave stays silent until the next start.
- R2: In a write transfer, the first byte after the address byte is loaded into the pointer and acknowledged. No write strobe is issued for it.
- R3: Each later byte of the write transfer is acknowledged. It is presented as `reg_wdata` at `reg_addr` = pointer, with a one-cycle `reg_wr_en`. The pointer then increments by one, so bursts fill consecutive locations.
- R4: A byte written while the pointer is below 0x07 or above 0x12 is still acknowledged, but no write strobe is issued, and the location keeps its value.
- R5: In a read transfer, the byte at the pointer is shifted out MSB first. A master acknowledge increments the pointer and sends the next byte. A master no-acknowledge sends the slave idle and leaves the pointer unchanged, so a following repeated-start read returns the same location.
- R6: A stop condition returns the slave to idle and sets the pointer to 0x00. A read right after a stop starts at location 0x00.
- R7: A repeated start is handled like a start, and the pointer keeps its value across it.
- R8: A read with the pointer above 0x12 returns 0xFF and issues no `reg_rd_en`.
- R9: Address byte 0x00 (general call) is acknowledged. If the next byte is 0x06, it is acknowledged and `gc_reset` pulses for one cycle. Any other byte gets no acknowledge and no pulse.
- R10: `read_active` rises when a read address byte is matched and stays high until the next stop condition. Every `reg_rd_en` falls within that window.
- R11: `sda_oe` changes only while SCL is low.
- R12: After reset, `sda_oe`, `read_active`, `reg_wr_en`, `reg_rd_en` and `gc_reset` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When high, the data line is pulled low |
| reg_addr | output | 8 | Register location, equal to the pointer |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Byte to write |
| reg_rd_en | output | 1 | One-cycle strobe for the cycle in which `reg_rdata` is taken |
| reg_rdata | input | 8 | Register contents at `reg_addr`, combinational |
| read_active | output | 1 | High from a read address match until stop |
| gc_reset | output | 1 | One-cycle pulse that restores all registers to defaults |

## Verification
The hardest state to reach is a pointer left unchanged after a master no-acknowledge. Any stop clears the pointer, so a stop would hide whether it moved. The stimulus therefore reads one location with an acknowledge and the next with a no-acknowledge. It then issues a repeated start and a fresh read without any stop, and expects the second location again. Address wrap-off is reached in a similar way: a burst that runs from the last writable location past the end of the map, and a read that continues past location 0x12.

// File: rtl/i2c_regport.sv
`timescale 1ns/1ps
module i2c_regport #(
  parameter logic [6:0] DEV_ADDR = 7'h48,
  parameter logic [7:0] FIRST_WR = 8'h07,
  parameter logic [7:0] LAST_REG = 8'h12,
  parameter logic [7:0] GC_CMD   = 8'h06,
  parameter logic [7:0] FILL     = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic       reg_wr_en,
  output logic [7:0] reg_wdata,
  output logic       reg_rd_en,
  input  logic [7:0] reg_rdata,
  output logic       read_active,
  output logic       gc_reset
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_TACK} state_t;
  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA, K_GC} kind_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  state_t     st;
  kind_t      kind;
  logic [3:0] bitcnt;
  logic [7:0] sh, ptr;
  logic       go_tx, gc_done, mack;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end

  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  assign scl_s     = scl_sy[1];
  assign sda_s     = sda_sy[1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

  logic byte_end, addr_hit, gc_hit, ptr_rd_ok, ptr_wr_ok, tx_load, ack_now;
  logic [7:0] tx_byte;
  assign byte_end  = (st == S_RX) && scl_fall && (bitcnt == 4'd8);
  assign addr_hit  = (sh[7:1] == DEV_ADDR);
  assign gc_hit    = (sh == 8'h00);
  assign ptr_rd_ok = (ptr <= LAST_REG);
  assign ptr_wr_ok = (ptr >= FIRST_WR) && (ptr <= LAST_REG);
  assign tx_load   = scl_fall && (((st == S_RACK) && go_tx) || ((st == S_TACK) && mack));
  assign tx_byte   = ptr_rd_ok ? reg_rdata : FILL;

  always_comb
    case (kind)
      K_ADDR:  ack_now = addr_hit | gc_hit;
      K_GC:    ack_now = (sh == GC_CMD);
      default: ack_now = 1'b1;
    endcase

  assign reg_addr  = ptr;
  assign reg_wdata = sh;
  assign reg_wr_en = byte_end && (kind == K_DATA) && ptr_wr_ok;
  assign reg_rd_en = tx_load && ptr_rd_ok;
  assign gc_reset  = byte_end && (kind == K_GC) && (sh == GC_CMD);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st          <= S_IDLE;
      kind        <= K_ADDR;
      bitcnt      <= 4'd0;
      sh          <= 8'h00;
      ptr         <= 8'h00;
      go_tx       <= 1'b0;
      gc_done     <= 1'b0;
      mack        <= 1'b0;
      sda_oe      <= 1'b0;
      read_active <= 1'b0;
    end else if (bus_stop) begin
      st          <= S_IDLE;
      ptr         <= 8'h00;
      sda_oe      <= 1'b0;
      read_active <= 1'b0;
    end else if (bus_start) begin
      st     <= S_RX;
      kind   <= K_ADDR;
      bitcnt <= 4'd0;
      sda_oe <= 1'b0;
    end else if (tx_load) begin
      sda_oe <= ~tx_byte[7];
      sh     <= {tx_byte[6:0], 1'b0};
      bitcnt <= 4'd1;
      st     <= S_TX;
    end else begin
      case (st)
        S_RX:
          if (scl_rise && bitcnt != 4'd8) begin
            sh     <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_end) begin
            bitcnt <= 4'd0;
            if (!ack_now) st <= S_IDLE;
            else begin
              st      <= S_RACK;
              sda_oe  <= 1'b1;
              go_tx   <= 1'b0;
              gc_done <= 1'b0;
              case (kind)
                K_ADDR:
                  if (addr_hit && sh[0]) begin
                    go_tx       <= 1'b1;
                    read_active <= 1'b1;
                  end else if (addr_hit) kind <= K_PTR;
                  else kind <= K_GC;
                K_PTR: begin
                  ptr  <= sh;
                  kind <= K_DATA;
                end
                K_DATA: ptr <= ptr + 8'd1;
                default: gc_done <= 1'b1;
              endcase
            end
          end
        S_RACK:
          if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= gc_done ? S_IDLE : S_RX;
          end
        S_TX:
          if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              st     <= S_TACK;
            end else begin
              sda_oe <= ~sh[7];
              sh     <= {sh[6:0], 1'b0};
              bitcnt <= bitcnt + 4'd1;
            end
          end
        S_TACK:
          if (scl_rise) begin
            mack <= ~sda_s;
            if (!sda_s) ptr <= ptr + 8'd1;
          end else if (scl_fall) st <= S_IDLE;
        default: ;
      endcase
    end

endmodule

// File: rtl/i2c_regport_chk.sv
`timescale 1ns/1ps
module i2c_regport_chk #(
  parameter logic [7:0] FIRST_WR = 8'h07,
  parameter logic [7:0] LAST_REG = 8'h12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic [7:0] reg_addr,
  input logic       reg_wr_en,
  input logic       reg_rd_en,
  input logic       read_active,
  input logic       gc_reset
);

  assert_wr_in_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> (reg_addr >= FIRST_WR && reg_addr <= LAST_REG));

  assert_rd_in_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |-> (reg_addr <= LAST_REG));

  assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  assert_no_wr_during_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_en));

  assert_gc_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reset |=> !gc_reset);

  assert_rd_in_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |-> read_active);

  assert_sda_moves_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

endmodule

bind i2c_regport i2c_regport_chk #(.FIRST_WR(FIRST_WR), .LAST_REG(LAST_REG)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .reg_addr(reg_addr),
  .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .read_active(read_active),
  .gc_reset(gc_reset)
);

// File: tb/i2c_regport_tb_top.sv
`timescale 1ns/1ps
module i2c_regport_tb_top;
  localparam int Q = 100;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_drv = 1'b1;
  logic sda_oe, reg_wr_en, reg_rd_en, read_active, gc_reset;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic sda_line;
  assign sda_line = sda_drv & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_regport dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata), .read_active(read_active),
    .gc_reset(gc_reset)
  );

  function automatic logic [7:0] dflt(int k);
    return 8'h30 + 8'(k);
  endfunction

  logic [7:0] regs [0:18];
  always @(posedge clk)
    if (!rst_n || gc_reset) begin
      for (int k = 0; k < 19; k++) regs[k] <= dflt(k);
    end else if (reg_wr_en && reg_addr <= 8'h12) regs[reg_addr[4:0]] <= reg_wdata;
  assign reg_rdata = (reg_addr <= 8'h12) ? regs[reg_addr[4:0]] : 8'h00;

  int nchk = 0, nfail = 0, bad_rd = 0, gc_cnt = 0, sda_bad = 0;
  bit done = 0;
  logic [7:0] exp_mem [0:18];
  logic [15:0] wr_q [$];
  logic prev_oe = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (reg_wr_en) begin
      if (wr_q.size() == 0) chk(0, "R4 unexpected write", {reg_addr, reg_wdata}, 0);
      else begin
        logic [15:0] e;
        e = wr_q.pop_front();
        chk({reg_addr, reg_wdata} == e, "R3 write item", {reg_addr, reg_wdata}, e);
      end
    end
    if (reg_rd_en && reg_addr > 8'h12) bad_rd++;
    if (gc_reset) gc_cnt++;
    if (sda_oe != prev_oe && scl) sda_bad++;
    prev_oe = sda_oe;
  end

  task automatic exp_wr(input logic [7:0] a, input logic [7:0] d);
    wr_q.push_back({a, d});
    exp_mem[a[4:0]] = d;
  endtask

  task automatic bstart();
    sda_drv = 1; #Q; scl = 1; #Q; sda_drv = 0; #Q; scl = 0; #Q;
  endtask

  task automatic bstop();
    sda_drv = 0; #Q; scl = 1; #Q; sda_drv = 1; #Q;
  endtask

  task automatic send_chk(input logic [7:0] b, input bit exp_ack, input string req);
    bit ack;
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; #Q; scl = 1; #Q; scl = 0; #Q;
    end
    sda_drv = 1; #Q; scl = 1; #(Q/2); ack = !sda_line; #(Q/2); scl = 0; #Q;
    chk(ack == exp_ack, req, ack, exp_ack);
  endtask

  task automatic read_chk(input bit mack, input logic [7:0] expv, input string req);
    logic [7:0] b;
    sda_drv = 1;
    for (int i = 7; i >= 0; i--) begin
      #Q; scl = 1; #(Q/2); b[i] = sda_line; #(Q/2); scl = 0;
    end
    sda_drv = !mack; #Q; scl = 1; #Q; scl = 0; #Q; sda_drv = 1;
    chk(b == expv, req, b, expv);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #900000;
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      report();
    end
  end

  initial begin
    for (int k = 0; k < 19; k++) exp_mem[k] = dflt(k);
    repeat (5) @(posedge clk);
    #1;
    chk(sda_oe == 0 && read_active == 0, "R12 reset outputs", {sda_oe, read_active}, 0);
    chk(reg_wr_en == 0 && reg_rd_en == 0 && gc_reset == 0, "R12 reset strobes",
        {reg_wr_en, reg_rd_en, gc_reset}, 0);
    rst_n = 1; #(2*Q);

    bstart(); send_chk(8'h92, 0, "R1 foreign address"); bstop();

    bstart(); send_chk(8'h90, 1, "R1 write address");
    send_chk(8'h07, 1, "R2 pointer byte");
    exp_wr(8'h07, 8'h11); send_chk(8'h11, 1, "R3 data ack");
    exp_wr(8'h08, 8'h22); send_chk(8'h22, 1, "R3 data ack");
    exp_wr(8'h09, 8'h33); send_chk(8'h33, 1, "R3 data ack");
    bstop(); #Q;
    chk(wr_q.size() == 0, "R3 burst complete", wr_q.size(), 0);

    bstart(); send_chk(8'h90, 1, "R1"); send_chk(8'h03, 1, "R2");
    send_chk(8'h55, 1, "R4 read-only location ack"); bstop();

    bstart(); send_chk(8'h90, 1, "R1"); send_chk(8'h11, 1, "R2");
    exp_wr(8'h11, 8'h66); send_chk(8'h66, 1, "R3");
    exp_wr(8'h12, 8'h77); send_chk(8'h77, 1, "R3");
    send_chk(8'h88, 1, "R4 past end ack"); bstop(); #Q;
    chk(wr_q.size() == 0, "R4 writes", wr_q.size(), 0);

    bstart(); send_chk(8'h91, 1, "R1 read address");
    chk(read_active == 1, "R10 active in read", read_active, 1);
    read_chk(1, exp_mem[0], "R6 read starts at zero");
    read_chk(1, exp_mem[1], "R5 increment");
    read_chk(0, exp_mem[2], "R5 increment");
    chk(read_active == 1, "R10 held until stop", read_active, 1);
    bstop(); #Q;
    chk(read_active == 0, "R10 cleared at stop", read_active, 0);

    bstart(); send_chk(8'h90, 1, "R1"); send_chk(8'h08, 1, "R2");
    bstart(); send_chk(8'h91, 1, "R7 repeated start");
    read_chk(1, exp_mem[8], "R7 pointer kept");
    read_chk(0, exp_mem[9], "R5");
    bstart(); send_chk(8'h91, 1, "R7");
    read_chk(0, exp_mem[9], "R5 nack keeps pointer");
    bstop();

    bstart(); send_chk(8'h90, 1, "R1"); send_chk(8'h03, 1, "R2");
    bstart(); send_chk(8'h91, 1, "R1");
    read_chk(0, dflt(3), "R4 location unchanged"); bstop();

    bstart(); send_chk(8'h90, 1, "R1"); send_chk(8'h12, 1, "R2");
    bstart(); send_chk(8'h91, 1, "R1");
    read_chk(1, exp_mem[18], "R3 last location");
    read_chk(0, 8'hFF, "R8 unmapped fill"); bstop();
    chk(bad_rd == 0, "R8 no strobe off map", bad_rd, 0);

    bstart(); send_chk(8'h00, 1, "R9 general call");
    send_chk(8'h05, 0, "R9 other command"); bstop();
    chk(gc_cnt == 0, "R9 no pulse", gc_cnt, 0);
    bstart(); send_chk(8'h00, 1, "R9 general call");
    send_chk(8'h06, 1, "R9 reset command"); bstop();
    chk(gc_cnt == 1, "R9 one pulse", gc_cnt, 1);
    for (int k = 0; k < 19; k++) exp_mem[k] = dflt(k);
    bstart(); send_chk(8'h90, 1, "R1"); send_chk(8'h07, 1, "R2");
    bstart(); send_chk(8'h91, 1, "R1");
    read_chk(1, exp_mem[7], "R9 defaults restored");
    read_chk(0, exp_mem[8], "R9 defaults restored"); bstop();

    #Q;
    chk(sda_bad == 0, "R11 data moves only with clock low", sda_bad, 0);
    chk(wr_q.size() == 0, "R3 queue drained", wr_q.size(), 0);
    done = 1;
    report();
  end
endmodule